// File: doc/BRIEF.md
# Grouped Three-Channel Compare Timer

The block holds three 16-bit up-counters. A single count strobe steps them all, and a small word-addressed register bus sets them up and reads them back. Each channel compares its counter with its own compare register. When the two are equal on a strobe, it raises a one-cycle match pulse. A per-channel clear-source field can make the counter return to zero on that match.

Any subset of the channels can be joined into one group that shares a time base. A bus write to the counter of a group member loads the same value into every member in the same clock edge. A member whose clear source is set to the synchronous code returns to zero on the same edge in which another member clears itself on its own match. In this way several compare channels can run against one common period.

Top module: `sync_timer_group`

## Requirements
- R1: After reset, every register reads 0, every counter is 0 and no match pulse is raised.
- R2: Word addresses: 0 = group mask (bit i for channel i), 1 = run mask (bit i for channel i). Channel i occupies base 4+4*i, with +0 = clear-source field in bits [2:0], +1 = counter and +2 = compare. All of these read back combinationally, and any other address reads 0.
- R3: On a clock edge with the count strobe high, a channel whose run bit is 1 adds one to its counter, wrapping from 0xFFFF to 0. A channel whose run bit is 0 holds its value.
- R4: match_pulse[i] is high for exactly the one cycle after an edge at which the strobe was high, run bit i was 1 and counter i equalled compare i.
- R5: With clear-source code 3'b001, that matching strobe edge loads 0 into the counter instead of incrementing it.
- R6: A bus write to the counter of a group member loads the written value into every group member on that edge. A write to a non-member's counter changes only that counter.
- R7: With clear-source code 3'b011, a group member loads 0 on the edge at which another group member clears on its own match. A non-member with that code ignores such clears. A channel with code 3'b011 never clears on its own match.
- R8: Clear-source codes other than 3'b001 and 3'b011 never clear the counter, so it keeps counting past its compare value.
- R9: A bus write, direct or through the group, wins over a clear and over an increment on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| count_strobe | input | 1 | Count enable for all running channels |
| match_pulse | output | 3 | Per-channel one-cycle compare-match pulse |

## Verification
The bench builds the block with its default parameters: three channels, 16-bit counters and a 4-bit address. With these values every register and every group subset are reachable with short directed sequences. Because the counters are 16 bits wide, the wrap from 0xFFFF is tested by presetting near the top, not by counting up to it. Small compare values then let own-match clears, group clears, a non-member that ignores group clears, and the write-over-clear and preset-over-strobe collisions all appear within a few strobes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // clear-source codes
   localparam logic [2:0] CLR_NONE = 3'b000;
   localparam logic [2:0] CLR_OWN  = 3'b001;
   localparam logic [2:0] CLR_SYNC = 3'b011;
   // register map
   localparam int ADR_GROUP = 0;
   localparam int ADR_RUN   = 1;
   localparam int CH_BASE   = 4;
   localparam int CH_STRIDE = 4;
   localparam int OFS_CTRL  = 0;
   localparam int OFS_CNT   = 1;
   localparam int OFS_CMP   = 2;
   localparam int SRC_W     = 3;
endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
   import tmr_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               bus_wr,
   input  logic [ADDR_W-1:0]                  bus_addr,
   input  logic [CNT_W-1:0]                   bus_wdata,
   output logic [NUM_CH-1:0]                  group_mask,
   output logic [NUM_CH-1:0]                  run_mask,
   output logic [NUM_CH-1:0][SRC_W-1:0]       clr_src,
   output logic [NUM_CH-1:0][CNT_W-1:0]       cmp_val,
   output logic [NUM_CH-1:0]                  cnt_wr
);
   localparam logic [ADDR_W-1:0] A_GROUP = ADDR_W'(ADR_GROUP);
   localparam logic [ADDR_W-1:0] A_RUN   = ADDR_W'(ADR_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         group_mask <= '0;
         run_mask   <= '0;
      end else if (bus_wr) begin
         if (bus_addr == A_GROUP) group_mask <= bus_wdata[NUM_CH-1:0];
         if (bus_addr == A_RUN)   run_mask   <= bus_wdata[NUM_CH-1:0];
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CH_BASE + CH_STRIDE*i + OFS_CTRL);
      localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(CH_BASE + CH_STRIDE*i + OFS_CNT);
      localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(CH_BASE + CH_STRIDE*i + OFS_CMP);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            clr_src[i] <= CLR_NONE;
            cmp_val[i] <= '0;
         end else if (bus_wr) begin
            if (bus_addr == A_CTRL) clr_src[i] <= bus_wdata[SRC_W-1:0];
            if (bus_addr == A_CMP)  cmp_val[i] <= bus_wdata;
         end
      end

      assign cnt_wr[i] = bus_wr && (bus_addr == A_CNT);
   end
endmodule

// File: rtl/tmr_sync_net.sv
module tmr_sync_net #(
   parameter int NUM_CH = 3
) (
   input  logic [NUM_CH-1:0] group_mask,
   input  logic [NUM_CH-1:0] cnt_wr,
   input  logic [NUM_CH-1:0] own_clr,
   output logic [NUM_CH-1:0] load,
   output logic              group_clr
);
   logic group_wr;

   // a write that lands on any member presets all members
   assign group_wr  = |(cnt_wr & group_mask);
   // only members clearing on their own match start a group clear
   assign group_clr = |(own_clr & group_mask);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ld
      assign load[i] = cnt_wr[i] | (group_mask[i] & group_wr);
   end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic             run,
   input  logic             in_group,
   input  logic [SRC_W-1:0] src,
   input  logic [CNT_W-1:0] cmp,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             group_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             own_clr,
   output logic             match
);
   logic step;
   logic hit;
   logic clr;

   assign step    = strobe & run;
   assign hit     = step & (cnt == cmp);
   assign own_clr = hit & (src == CLR_OWN);
   assign clr     = own_clr | (in_group & (src == CLR_SYNC) & group_clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         match <= 1'b0;
      end else begin
         match <= hit;
         if (load)      cnt <= load_val;
         else if (clr)  cnt <= '0;
         else if (step) cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sync_timer_group.sv
module sync_timer_group
   import tmr_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic              count_strobe,
   output logic [NUM_CH-1:0] match_pulse
);
   localparam int ADDR_SPAN = CH_BASE + CH_STRIDE*NUM_CH;

   initial begin
      assert (NUM_CH >= 1 && NUM_CH <= CNT_W) else $error("NUM_CH out of range");
      assert (CNT_W >= SRC_W) else $error("CNT_W too narrow");
      assert (ADDR_SPAN <= (1 << ADDR_W)) else $error("ADDR_W too narrow");
   end

   logic [NUM_CH-1:0]             group_mask_q;
   logic [NUM_CH-1:0]             run_mask_q;
   logic [NUM_CH-1:0][SRC_W-1:0]  clr_src_q;
   logic [NUM_CH-1:0][CNT_W-1:0]  cmp_q;
   logic [NUM_CH-1:0][CNT_W-1:0]  cnt_q;
   logic [NUM_CH-1:0]             cnt_wr;
   logic [NUM_CH-1:0]             own_clr;
   logic [NUM_CH-1:0]             load;
   logic                          group_clr;

   tmr_regfile #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .group_mask (group_mask_q),
      .run_mask   (run_mask_q),
      .clr_src    (clr_src_q),
      .cmp_val    (cmp_q),
      .cnt_wr     (cnt_wr)
   );

   tmr_sync_net #(.NUM_CH(NUM_CH)) u_net (
      .group_mask (group_mask_q),
      .cnt_wr     (cnt_wr),
      .own_clr    (own_clr),
      .load       (load),
      .group_clr  (group_clr)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      tmr_channel #(.CNT_W(CNT_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .strobe    (count_strobe),
         .run       (run_mask_q[i]),
         .in_group  (group_mask_q[i]),
         .src       (clr_src_q[i]),
         .cmp       (cmp_q[i]),
         .load      (load[i]),
         .load_val  (bus_wdata),
         .group_clr (group_clr),
         .cnt       (cnt_q[i]),
         .own_clr   (own_clr[i]),
         .match     (match_pulse[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADR_GROUP)) bus_rdata = CNT_W'(group_mask_q);
      if (bus_addr == ADDR_W'(ADR_RUN))   bus_rdata = CNT_W'(run_mask_q);
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*i + OFS_CTRL)) bus_rdata = CNT_W'(clr_src_q[i]);
         if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*i + OFS_CNT))  bus_rdata = cnt_q[i];
         if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*i + OFS_CMP))  bus_rdata = cmp_q[i];
      end
   end
endmodule

// File: rtl/sync_timer_group_chk.sv
module sync_timer_group_chk #(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          bus_wr,
   input logic [ADDR_W-1:0]             bus_addr,
   input logic [CNT_W-1:0]              bus_wdata,
   input logic                          count_strobe,
   input logic [NUM_CH-1:0]             match_pulse,
   input logic [NUM_CH-1:0][CNT_W-1:0]  cnt_q,
   input logic [NUM_CH-1:0][CNT_W-1:0]  cmp_q,
   input logic [NUM_CH-1:0][2:0]        clr_src_q,
   input logic [NUM_CH-1:0]             group_mask_q,
   input logic [NUM_CH-1:0]             run_mask_q
);
   logic [NUM_CH-1:0] wr_hit;
   logic [NUM_CH-1:0] self_ev;
   logic [NUM_CH-1:0] touched;
   logic              grp_wr;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ev
      assign wr_hit[c]  = bus_wr && (bus_addr == ADDR_W'(4 + 4*c + 1));
      assign self_ev[c] = count_strobe && run_mask_q[c] && (cnt_q[c] == cmp_q[c])
                          && (clr_src_q[c] == 3'b001) && group_mask_q[c];
   end
   assign grp_wr = |(wr_hit & group_mask_q);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_t
      assign touched[c] = wr_hit[c] || (group_mask_q[c] && grp_wr);
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_a
      AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (!run_mask_q[c] && !touched[c] && clr_src_q[c] != 3'b011) |=> $stable(cnt_q[c])); // R3
      AST_MATCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rst_n) || 1'b1 ##0 match_pulse[c] |->
            $past(count_strobe && run_mask_q[c] && cnt_q[c] == cmp_q[c])); // R4
      AST_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (count_strobe && run_mask_q[c] && cnt_q[c] == cmp_q[c] && clr_src_q[c] == 3'b001
          && !touched[c]) |=> (cnt_q[c] == '0)); // R5
      AST_PRESET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
         touched[c] |=> (cnt_q[c] == $past(bus_wdata))); // R6
      AST_GROUP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (group_mask_q[c] && clr_src_q[c] == 3'b011 && |self_ev && !touched[c])
            |=> (cnt_q[c] == '0)); // R7
      AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         (touched[c] && count_strobe && run_mask_q[c]) |=> (cnt_q[c] == $past(bus_wdata))); // R9
   end
endmodule

bind sync_timer_group sync_timer_group_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr       (bus_wr),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .count_strobe (count_strobe),
   .match_pulse  (match_pulse),
   .cnt_q        (cnt_q),
   .cmp_q        (cmp_q),
   .clr_src_q    (clr_src_q),
   .group_mask_q (group_mask_q),
   .run_mask_q   (run_mask_q)
);

// File: tb/sync_timer_group_tb.sv
module sync_timer_group_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        count_strobe = 1'b0;
   logic [2:0]  match_pulse;

   int checks = 0;
   int errors = 0;

   sync_timer_group u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .count_strobe(count_strobe), .match_pulse(match_pulse)
   );

   always #2 clk = ~clk;

   function automatic logic [3:0] a_ctl(input int c); return 4'(4 + 4*c); endfunction
   function automatic logic [3:0] a_cnt(input int c); return 4'(5 + 4*c); endfunction
   function automatic logic [3:0] a_cmp(input int c); return 4'(6 + 4*c); endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic strb = 1'b0);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; count_strobe = strb;
      @(negedge clk);
      bus_wr = 1'b0; count_strobe = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic strobes(input int n);
      repeat (n) begin
         @(negedge clk);
         count_strobe = 1'b1;
      end
      @(negedge clk);
      count_strobe = 1'b0;
   endtask

   task automatic clean();
      wr(4'd0, 16'h0); wr(4'd1, 16'h0);
      for (int c = 0; c < 3; c++) begin
         wr(a_ctl(c), 16'h0); wr(a_cnt(c), 16'h0); wr(a_cmp(c), 16'h0);
      end
   endtask

   task automatic t_reset();
      logic [15:0] d;
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), d);
         check("R1 reg after reset", d, 16'h0);
      end
      check("R1 match after reset", 16'(match_pulse), 16'h0);
   endtask

   task automatic t_regmap();
      logic [15:0] d;
      wr(4'd0, 16'h0005); wr(4'd1, 16'h0006);
      wr(a_ctl(1), 16'h0003); wr(a_cmp(2), 16'h1234); wr(a_cnt(0), 16'hBEEF);
      rd(4'd0, d);     check("R2 group mask", d, 16'h0005);
      rd(4'd1, d);     check("R2 run mask", d, 16'h0006);
      rd(a_ctl(1), d); check("R2 ch1 clear src", d, 16'h0003);
      rd(a_cmp(2), d); check("R2 ch2 compare", d, 16'h1234);
      rd(a_cnt(0), d); check("R2 ch0 counter", d, 16'hBEEF);
      rd(4'd3, d);     check("R2 unmapped", d, 16'h0);
      clean();
   endtask

   task automatic t_count();
      logic [15:0] d;
      wr(4'd1, 16'h0003);
      strobes(5);
      rd(a_cnt(0), d); check("R3 ch0 counts", d, 16'd5);
      rd(a_cnt(1), d); check("R3 ch1 counts", d, 16'd5);
      rd(a_cnt(2), d); check("R3 ch2 stopped", d, 16'd0);
      wr(a_cnt(0), 16'hFFFF);
      strobes(1);
      rd(a_cnt(0), d); check("R3 wrap", d, 16'h0000);
      clean();
   endtask

   task automatic t_own_clear();
      logic [15:0] d;
      wr(a_ctl(0), 16'h1); wr(a_ctl(1), 16'h2); wr(a_ctl(2), 16'h4);
      for (int c = 0; c < 3; c++) wr(a_cmp(c), 16'd3);
      wr(4'd1, 16'h0007);
      strobes(3);
      check("R4 no match before", 16'(match_pulse), 16'h0);
      @(negedge clk); count_strobe = 1'b1;
      @(negedge clk); count_strobe = 1'b0;
      check("R4 match pulse", 16'(match_pulse), 16'h7);
      rd(a_cnt(0), d); check("R5 own clear", d, 16'd0);
      rd(a_cnt(1), d); check("R8 code 010 no clear", d, 16'd4);
      rd(a_cnt(2), d); check("R8 code 100 no clear", d, 16'd4);
      @(negedge clk);
      check("R4 pulse one cycle", 16'(match_pulse), 16'h0);
      clean();
   endtask

   task automatic t_preset();
      logic [15:0] d;
      wr(4'd0, 16'h0003);
      wr(a_cnt(2), 16'h0055);
      wr(a_cnt(1), 16'h0100);
      rd(a_cnt(0), d); check("R6 preset member0", d, 16'h0100);
      rd(a_cnt(1), d); check("R6 preset member1", d, 16'h0100);
      rd(a_cnt(2), d); check("R6 nonmember untouched", d, 16'h0055);
      wr(a_cnt(2), 16'h0077);
      rd(a_cnt(0), d); check("R6 nonmember write isolated", d, 16'h0100);
      rd(a_cnt(2), d); check("R6 nonmember write", d, 16'h0077);
      clean();
   endtask

   task automatic t_sync_clear();
      logic [15:0] d;
      wr(4'd0, 16'h0003);
      wr(a_ctl(0), 16'h1); wr(a_cmp(0), 16'd5);
      wr(a_ctl(1), 16'h3); wr(a_cmp(1), 16'd2);
      wr(a_ctl(2), 16'h3);
      wr(4'd1, 16'h0007);
      strobes(3);
      rd(a_cnt(1), d); check("R7 sync code no self clear", d, 16'd3);
      strobes(3);
      rd(a_cnt(0), d); check("R7 initiator cleared", d, 16'd0);
      rd(a_cnt(1), d); check("R7 member follows clear", d, 16'd0);
      rd(a_cnt(2), d); check("R7 nonmember ignores", d, 16'd6);
      clean();
   endtask

   task automatic t_priority();
      logic [15:0] d;
      wr(a_ctl(0), 16'h1); wr(a_cmp(0), 16'd5); wr(a_cnt(0), 16'd5);
      wr(4'd1, 16'h0007);
      wr(a_cnt(0), 16'h0042, 1'b1);
      rd(a_cnt(0), d); check("R9 write beats clear", d, 16'h0042);
      wr(a_ctl(0), 16'h0);
      wr(4'd0, 16'h0003);
      wr(a_cnt(2), 16'h0020);
      wr(a_cnt(1), 16'h0010, 1'b1);
      rd(a_cnt(0), d); check("R9 preset beats strobe m0", d, 16'h0010);
      rd(a_cnt(1), d); check("R9 preset beats strobe m1", d, 16'h0010);
      rd(a_cnt(2), d); check("R9 nonmember still counts", d, 16'h0021);
      clean();
   endtask

   initial begin
      #400000;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_count();
      t_own_clear();
      t_preset();
      t_sync_clear();
      t_priority();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule